// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block sits between a synchronous host and an asynchronous 1M x 16 extended-data-out DRAM. The host raises a request with a 20-bit word address, a read/write flag, 16 bits of write data and two byte enables. It holds the request until the controller returns a one-cycle acknowledge. For reads, the data comes back with that acknowledge. The controller sends the word address over a 10-bit multiplexed bus: the upper ten bits go out as the row and the lower ten bits go out as the column. A separate active-low column strobe serves each byte lane, so a byte access asserts only the strobe of the lane it touches.

After an access the controller leaves the row open. A later request to the same row skips activation and runs only a column cycle. A request to another row first closes the row and waits out the precharge time. A divider counts controller cycles and marks a refresh as pending once per refresh interval. A pending refresh is served before any new host request, using the CAS-before-RAS order. Every DRAM timing is a parameter in picoseconds, converted into whole controller cycles and rounded up.

The state machine has these states:
- ST_IDLE: waits, with the row either open or closed.
- ST_ACT: row activation.
- ST_CSETUP: column address, write enable and output enable set up while the column strobes are still high.
- ST_CAS: column strobe low. Read data is sampled at the end of this state.
- ST_CPRE: column strobe precharge.
- ST_PRE: row precharge.
- ST_RCAS: both column strobes low ahead of the row strobe.
- ST_RRAS: row strobe low during refresh.

The transitions are:
- IDLE→PRE: a refresh is pending, or there is a row miss, while a row is open.
- IDLE→RCAS: a refresh is pending and the row is closed.
- IDLE→CSETUP: a row hit.
- IDLE→ACT: a request while the row is closed.
- ACT→CSETUP, CSETUP→CAS, CAS→CPRE, CPRE→IDLE, RCAS→RRAS and RRAS→PRE: each taken when its timer expires.
- PRE→IDLE: taken once the precharge count and the row-cycle guard have both expired.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During and right after reset, the row strobe, both column strobes, write enable and output enable are high (inactive), the data drive enable and acknowledge are low.
- R2: A write followed by a read of the same word returns the written data. Address bits 19:10 appear on the DRAM address bus when the row strobe falls, and bits 9:0 appear when the column strobe falls.
- R3: Host byte enable bit 1 drives the upper column strobe (data bits 15:8), and bit 0 drives the lower strobe (bits 7:0). A write changes only the enabled lanes. A read returns zero in lanes that are not enabled.
- R4: A request to the row already open produces no new row-strobe fall. A request to a different row closes the row and activates the new one exactly once.
- R5: Refresh drives both column strobes low at least one cycle before the row strobe falls, with write enable high. One refresh is issued per refresh interval, and it is delayed at most by the access in progress and one precharge.
- R6: A host request made while a refresh is pending or running gets no acknowledge until that refresh's row-strobe pulse has occurred.
- R7: For writes, write enable is low and data is driven at least one cycle before a column strobe falls, and output enable stays high. For reads, write enable stays high and output enable is low. Write enable and output enable are never low together.
- R8: Consecutive row-strobe falls are at least tRC (85 ns) apart, and the row strobe stays high at least tRP (30 ns) before each fall.
- R9: Column-strobe falls within one open row are at least tPC (30 ns) apart. Read data is captured only after the column strobe has been low for at least tAA (25 ns, which also covers tCAC) and at least tRAC (50 ns) after the row strobe fell.
- R10: Each request gets exactly one acknowledge, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address, row in the upper half |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 1 = upper lane |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | 16 | Read data, valid with acknowledge |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data drive enable |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
Directed sequences right after a refresh separate three cases by counting row-strobe falls: a first access to a closed row, page hits within that row, and a row miss. A request raised while both column strobes are already low for refresh shows that refresh holds off the host. Random traffic concentrated on four rows, with mixed byte enables and read/write flags, mixes hits, misses and refresh interruptions. A behavioural memory catches lane-masking or address-split errors, and every strobe edge is timed against the minimum intervals.

// File: rtl/edo_ctrl_pkg.sv
`timescale 1ns/1ps
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_CSETUP,
        ST_CAS,
        ST_CPRE,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } ctrl_state_t;

    function automatic int ceil_cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_wait_timer.sv
`timescale 1ns/1ps
module edo_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_refresh_timer.sv
`timescale 1ns/1ps
module edo_refresh_timer #(
    parameter int PERIOD = 1954
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic pend
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt;
    logic         tick;

    assign tick = (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
                pend <= 1'b1;
            end else if (clr) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int MUX_W     = 10,
    parameter int DQ_W      = 16,
    parameter int CNT_W     = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_RCD_PS  = 20000,
    parameter int T_RAC_PS  = 50000,
    parameter int T_CAC_PS  = 14000,
    parameter int T_AA_PS   = 25000,
    parameter int T_PC_PS   = 30000,
    parameter int T_RC_PS   = 85000,
    parameter int T_RP_PS   = 30000,
    parameter int T_CSR_PS  = 10000,
    parameter int T_RASR_PS = 50000,
    parameter int REFI_PS   = 15625000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_wr,
    input  logic [2*MUX_W-1:0]   host_addr,
    input  logic [DQ_W-1:0]      host_wdata,
    input  logic [1:0]           host_be,
    output logic                 host_ack,
    output logic [DQ_W-1:0]      host_rdata,
    output logic [MUX_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_ucas_n,
    output logic                 dram_lcas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DQ_W-1:0]      dram_dq_out,
    output logic                 dram_dq_oe,
    input  logic [DQ_W-1:0]      dram_dq_in
);
    localparam int HALF_W  = DQ_W / 2;
    localparam int N_RCD   = max2(1, ceil_cyc(T_RCD_PS, CLK_PS));
    localparam int N_COL   = max2(1, max2(ceil_cyc(T_CAC_PS, CLK_PS), ceil_cyc(T_AA_PS, CLK_PS)));
    localparam int N_COL_F = max2(N_COL, ceil_cyc(T_RAC_PS, CLK_PS) - N_RCD - 1);
    localparam int N_CP    = max2(1, ceil_cyc(T_PC_PS, CLK_PS) - N_COL - 1);
    localparam int N_RC    = max2(1, ceil_cyc(T_RC_PS, CLK_PS));
    localparam int N_RP    = max2(1, ceil_cyc(T_RP_PS, CLK_PS));
    localparam int N_CSR   = max2(1, ceil_cyc(T_CSR_PS, CLK_PS));
    localparam int N_RASR  = max2(1, ceil_cyc(T_RASR_PS, CLK_PS));
    localparam int REF_PER = max2(2, ceil_cyc(REFI_PS, CLK_PS));

    ctrl_state_t      state, nxt;
    logic             wt_load, wt_done, rc_load, rc_done, ref_pend, ref_clr;
    logic [CNT_W-1:0] wt_val;
    logic             row_open, fresh, lat_wr, row_hit;
    logic [MUX_W-1:0] open_row, lat_col;
    logic [DQ_W-1:0]  lat_wdata, lane_mask;
    logic [1:0]       lat_be;

    edo_wait_timer #(.CNT_W(CNT_W)) u_phase_timer (
        .clk(clk), .rst_n(rst_n), .load(wt_load), .load_val(wt_val), .done(wt_done)
    );

    edo_wait_timer #(.CNT_W(CNT_W)) u_rc_guard (
        .clk(clk), .rst_n(rst_n), .load(rc_load),
        .load_val(CNT_W'(N_RC - 1)), .done(rc_done)
    );

    edo_refresh_timer #(.PERIOD(REF_PER)) u_refresh (
        .clk(clk), .rst_n(rst_n), .clr(ref_clr), .pend(ref_pend)
    );

    assign row_hit   = row_open && (host_addr[2*MUX_W-1:MUX_W] == open_row);
    assign rc_load   = (state != nxt) && ((nxt == ST_ACT) || (nxt == ST_RRAS));
    assign ref_clr   = (state == ST_IDLE) && (nxt == ST_RCAS);
    assign lane_mask = {{HALF_W{lat_be[1]}}, {HALF_W{lat_be[0]}}};

    // next state and phase-timer load
    always_comb begin
        nxt     = state;
        wt_load = 1'b0;
        wt_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    if (row_open) begin
                        nxt = ST_PRE;  wt_load = 1'b1; wt_val = CNT_W'(N_RP - 1);
                    end else if (rc_done) begin
                        nxt = ST_RCAS; wt_load = 1'b1; wt_val = CNT_W'(N_CSR - 1);
                    end
                end else if (host_req) begin
                    if (row_hit) begin
                        nxt = ST_CSETUP; wt_load = 1'b1; wt_val = '0;
                    end else if (row_open) begin
                        nxt = ST_PRE;    wt_load = 1'b1; wt_val = CNT_W'(N_RP - 1);
                    end else if (rc_done) begin
                        nxt = ST_ACT;    wt_load = 1'b1; wt_val = CNT_W'(N_RCD - 1);
                    end
                end
            end
            ST_ACT: if (wt_done) begin
                nxt = ST_CSETUP; wt_load = 1'b1; wt_val = '0;
            end
            ST_CSETUP: if (wt_done) begin
                nxt = ST_CAS; wt_load = 1'b1;
                wt_val = fresh ? CNT_W'(N_COL_F - 1) : CNT_W'(N_COL - 1);
            end
            ST_CAS: if (wt_done) begin
                nxt = ST_CPRE; wt_load = 1'b1; wt_val = CNT_W'(N_CP - 1);
            end
            ST_CPRE: if (wt_done) nxt = ST_IDLE;
            ST_PRE:  if (wt_done && rc_done) nxt = ST_IDLE;
            ST_RCAS: if (wt_done) begin
                nxt = ST_RRAS; wt_load = 1'b1; wt_val = CNT_W'(N_RASR - 1);
            end
            ST_RRAS: if (wt_done) begin
                nxt = ST_PRE; wt_load = 1'b1; wt_val = CNT_W'(N_RP - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and per-access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            row_open   <= 1'b0;
            open_row   <= '0;
            fresh      <= 1'b0;
            lat_col    <= '0;
            lat_wr     <= 1'b0;
            lat_wdata  <= '0;
            lat_be     <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            state    <= nxt;
            host_ack <= 1'b0;
            if (state == ST_IDLE && host_req && !ref_pend) begin
                lat_col   <= host_addr[MUX_W-1:0];
                lat_wr    <= host_wr;
                lat_wdata <= host_wdata;
                lat_be    <= host_be;
            end
            if (state == ST_IDLE && nxt == ST_ACT) begin
                row_open <= 1'b1;
                open_row <= host_addr[2*MUX_W-1:MUX_W];
                fresh    <= 1'b1;
            end
            if (state != ST_PRE && nxt == ST_PRE) begin
                row_open <= 1'b0;
            end
            if (state == ST_CAS && wt_done) begin
                host_ack <= 1'b1;
                fresh    <= 1'b0;
                if (!lat_wr) host_rdata <= dram_dq_in & lane_mask;
            end
        end
    end

    // strobe decode
    always_comb begin
        dram_ras_n  = !(row_open || state == ST_RRAS);
        dram_ucas_n = 1'b1;
        dram_lcas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = open_row;
        dram_dq_out = lat_wdata;
        unique case (state)
            ST_CSETUP, ST_CAS: begin
                dram_addr  = lat_col;
                dram_we_n  = !lat_wr;
                dram_oe_n  = lat_wr;
                dram_dq_oe = lat_wr;
                if (state == ST_CAS) begin
                    dram_ucas_n = !lat_be[1];
                    dram_lcas_n = !lat_be[0];
                end
            end
            ST_RCAS, ST_RRAS: begin
                dram_ucas_n = 1'b0;
                dram_lcas_n = 1'b0;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    logic             ras_prev;
    logic [CNT_W-1:0] ras_gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            ras_gap  <= CNT_W'(N_RC);
        end else begin
            ras_prev <= dram_ras_n;
            if (ras_prev && !dram_ras_n) ras_gap <= CNT_W'(1);
            else if (ras_gap < CNT_W'(N_RC)) ras_gap <= ras_gap + 1'b1;
        end
    end

    assert_cbr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_ucas_n && !dram_lcas_n)
        |-> ($past(!dram_ucas_n && !dram_lcas_n) && dram_we_n))
        else $error("CBR order violated");

    assert_we_before_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_ucas_n) || $fell(dram_lcas_n)) && !dram_we_n) |-> $past(!dram_we_n))
        else $error("write enable late");

    assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n)
        else $error("we and oe both active");

    assert_ras_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_gap >= CNT_W'(N_RC)))
        else $error("row cycle too short");

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack)
        else $error("ack wider than one cycle");

endmodule

// File: tb/edo_dram_ctrl_test.sv
`timescale 1ns/1ps
module edo_dram_ctrl_test;
    localparam int REFI_PS = 1200000;   // 150 cycles at 8 ns
    localparam int REF_CYC = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = 2'b11;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    always #4 clk = ~clk;

    edo_dram_ctrl #(.REFI_PS(REFI_PS)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ack(host_ack), .host_rdata(host_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [15:0] dmem [int];
    logic [15:0] rmem [int];

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return (old & ~lane_mask(be)) | (nw & lane_mask(be));
    endfunction

    function automatic logic [15:0] ref_get(input int a);
        return rmem.exists(a) ? rmem[a] : 16'h0;
    endfunction

    // access context seen by the DRAM model
    logic        cur_wr = 1'b0;
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = 2'b11;

    // DRAM model and timing monitor, cycle based at negedge
    int  cyc = 0, act_cnt = 0, ref_cnt = 0, last_ref = -1, max_ref_gap = 0;
    int  last_ras_fall = -1000, last_ras_rise = -1000, last_col_fall = -1000;
    bit  prev_ras = 1, prev_cl = 0, prev_we = 1;
    logic [9:0] m_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit cl;
            int key;
            cyc++;
            cl = !dram_ucas_n || !dram_lcas_n;
            if (prev_ras && !dram_ras_n) begin
                chk((cyc - last_ras_fall) * 8 >= 85, "R8", "ras-to-ras ns", (cyc - last_ras_fall) * 8, 85);
                chk((cyc - last_ras_rise) * 8 >= 30, "R8", "ras precharge ns", (cyc - last_ras_rise) * 8, 30);
                if (cl) begin
                    chk(!dram_ucas_n && !dram_lcas_n && prev_cl && dram_we_n, "R5", "cbr order",
                        {dram_ucas_n, dram_lcas_n, prev_cl, dram_we_n}, 4'b0011);
                    ref_cnt++;
                    if (last_ref >= 0 && cyc - last_ref > max_ref_gap) max_ref_gap = cyc - last_ref;
                    last_ref = cyc;
                end else begin
                    act_cnt++;
                    m_row = dram_addr;
                end
                last_ras_fall = cyc;
            end
            if (!prev_ras && dram_ras_n) last_ras_rise = cyc;
            if (!prev_cl && cl && !dram_ras_n) begin
                if (last_col_fall > last_ras_fall)
                    chk((cyc - last_col_fall) * 8 >= 30, "R9", "page cycle ns", (cyc - last_col_fall) * 8, 30);
                last_col_fall = cyc;
                key = int'({m_row, dram_addr});
                chk({m_row, dram_addr} == cur_addr, "R2", "row/col mux", {m_row, dram_addr}, cur_addr);
                chk((!dram_ucas_n == cur_be[1]) && (!dram_lcas_n == cur_be[0]), "R3", "lane strobes",
                    {!dram_ucas_n, !dram_lcas_n}, cur_be);
                chk(dram_we_n == !cur_wr && dram_oe_n == cur_wr, "R7", "we/oe levels",
                    {dram_we_n, dram_oe_n}, {!cur_wr, cur_wr});
                if (cur_wr) begin
                    chk(!prev_we && dram_dq_oe, "R7", "we/data before cas", {prev_we, dram_dq_oe}, 2'b01);
                    dmem[key] = merge(dmem.exists(key) ? dmem[key] : 16'h0, dram_dq_out,
                                      {!dram_ucas_n, !dram_lcas_n});
                end else begin
                    dram_dq_in <= dmem.exists(key) ? dmem[key] : 16'h0;
                end
            end
            if (prev_cl && !cl && !dram_ras_n && !cur_wr) begin
                chk((cyc - last_col_fall) * 8 >= 25, "R9", "cas low ns", (cyc - last_col_fall) * 8, 25);
                chk((cyc - last_ras_fall) * 8 >= 50, "R9", "ras low ns", (cyc - last_ras_fall) * 8, 50);
            end
            prev_ras = dram_ras_n;
            prev_cl  = cl;
            prev_we  = dram_we_n;
        end
    end

    task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] wd,
                          input logic [1:0] be, output logic [15:0] rd);
        int n = 0;
        cur_wr = wr; cur_addr = a; cur_be = be;
        host_wr = wr; host_addr = a; host_wdata = wd; host_be = be; host_req = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 400);
        chk(host_ack, "R10", "ack arrives", host_ack, 1);
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_ack, "R10", "ack one cycle", host_ack, 0);
        if (wr) rmem[int'(a)] = merge(ref_get(int'(a)), wd, be);
    endtask

    task automatic rd_check(input logic [19:0] a, input logic [1:0] be, input string req);
        logic [15:0] got, exp;
        access(1'b0, a, 16'h0, be, got);
        exp = ref_get(int'(a)) & lane_mask(be);
        chk(got == exp, req, "read data", got, exp);
    endtask

    task automatic wr_do(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] dummy;
        access(1'b1, a, d, be, dummy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "ALL", "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a0, r0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1f && !host_ack && !dram_dq_oe,
            "R1", "strobes in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1f && !host_ack && !dram_dq_oe,
            "R1", "strobes after reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);

        // R4 page hit / miss right after the first refresh
        while (!(ref_cnt == 1 && dram_ras_n)) @(negedge clk);
        a0 = act_cnt;
        wr_do({10'd5, 10'd3}, 16'hBEEF, 2'b11);
        chk(act_cnt == a0 + 1, "R4", "closed row activates", act_cnt - a0, 1);
        wr_do({10'd5, 10'd7}, 16'h1234, 2'b01);
        rd_check({10'd5, 10'd3}, 2'b11, "R2");
        rd_check({10'd5, 10'd7}, 2'b11, "R3");
        chk(act_cnt == a0 + 1, "R4", "page hits no activation", act_cnt - a0, 1);
        rd_check({10'd9, 10'd3}, 2'b11, "R2");
        chk(act_cnt == a0 + 2, "R4", "row miss activates once", act_cnt - a0, 2);

        // R3 lane merge
        wr_do({10'd9, 10'd40}, 16'hAAAA, 2'b11);
        wr_do({10'd9, 10'd40}, 16'h1255, 2'b10);
        rd_check({10'd9, 10'd40}, 2'b11, "R3");
        rd_check({10'd9, 10'd40}, 2'b01, "R3");

        // R6 request held by running refresh
        while (!(!dram_ucas_n && !dram_lcas_n && dram_ras_n)) @(negedge clk);
        r0 = ref_cnt;
        rd_check({10'd5, 10'd3}, 2'b11, "R6");
        chk(ref_cnt == r0 + 1, "R6", "refresh before ack", ref_cnt - r0, 1);

        // random traffic over four rows
        void'($urandom(32'h5eed));
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            logic [1:0]  be;
            a  = {10'h100 + 10'($urandom % 4), 10'($urandom % 16)};
            be = 2'($urandom % 3 + 1);
            if ($urandom % 2) wr_do(a, 16'($urandom), be);
            else rd_check(a, be, "R2");
        end

        // R5 refresh rate
        chk(ref_cnt >= cyc / REF_CYC - 1, "R5", "refresh count", ref_cnt, cyc / REF_CYC - 1);
        chk(max_ref_gap <= REF_CYC + 40, "R5", "max refresh gap", max_ref_gap, REF_CYC + 40);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule